// File: doc/BRIEF.md
# Indirect Data Address Generator

This block turns the data-memory operand of an 8-bit core into a 12-bit linear address. It holds three 12-bit pointer registers. It recognises accesses to a small window of virtual registers for each pointer: plain indirect, post-increment, post-decrement, pre-increment and W-indexed. For each of these it produces the pointer-derived effective address and commits the pointer update on the clock edge of the access. The pointers can also be read and written directly at their own byte addresses.

Operands that do not use bank-select addressing are mapped into a low and a high window of the address space. When the extended mode input is set, operands at or below 5Fh instead become offsets from pointer 2. An indirect access whose result lands on another virtual register reads as zero and has its write blocked. An indirect write whose result lands on a pointer byte loads that byte with no pointer stepping. The ALU and the memory array sit outside this block and consume `eff_addr`, `rd_zero` and `wr_block`.

Top module: `ind_addr_gen`

## Requirements
- R1: After reset all three pointers read as 000h through their direct byte addresses.
- R2: With `opd_bank`=1 the operand address is `{bank_sel, opd_addr}`.
- R3: With `opd_bank`=0 and `ext_mode`=0, operands 00h..5Fh map to 000h..05Fh and operands 60h..FFh map to F60h..FFFh.
- R4: With `ext_mode`=1 and `opd_bank`=0, an operand at or below 5Fh yields pointer 2 plus the operand, modulo 4096. Operands of 60h or above, and bank-select operands, resolve as in R2/R3.
- R5: The virtual register window of pointer n runs downward from FEFh−8n: plain (FEFh−8n), post-increment, post-decrement, pre-increment, W-indexed, high byte, low byte (FE9h−8n). Plain, post-increment and post-decrement accesses output the pointer as the effective address. On a strobe the pointer steps by +1 or −1 across all 12 bits, with carry and borrow. A pointer steps only once per cycle, even when read and write strobes are both set.
- R6: A pre-increment access outputs pointer+1 and leaves the pointer at pointer+1.
- R7: A W-indexed access outputs pointer plus `w_val`, taken as a signed 8-bit value, modulo 4096. The pointer is unchanged.
- R8: If an indirect access's effective address falls in any pointer's virtual window (plain..W-indexed), `rd_zero` equals `rd_stb` and `wr_block` equals `wr_stb`. Otherwise both are 0.
- R9: A pointer byte address reached directly returns its value on `ptr_rdata`. The high byte reads `{4'h0, bits 11:8}`. A write loads the byte, and only the low 4 data bits are kept for the high byte. All other addresses give `ptr_rdata` = 00h.
- R10: An indirect write whose effective address is a pointer byte loads `wr_data` into that byte and applies no post- or pre-modify step.
- R11: Accesses through pointers 0 and 1 behave the same whatever the value of `ext_mode`.
- R12: Pointers change only on a clock edge where `rd_stb` or `wr_stb` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| opd_addr | input | 8 | File address field of the instruction |
| opd_bank | input | 1 | 1 = bank-select addressing, 0 = access-window addressing |
| bank_sel | input | 4 | Bank select value |
| w_val | input | 8 | Working register, used as the signed index |
| ext_mode | input | 1 | Extended (pointer 2 relative) operand mode enable |
| rd_stb | input | 1 | Data read in this cycle |
| wr_stb | input | 1 | Data write in this cycle |
| wr_data | input | 8 | Write data, used when the target is a pointer byte |
| eff_addr | output | 12 | Resolved effective address |
| rd_zero | output | 1 | Read of this access must return 00h |
| wr_block | output | 1 | Write of this access must be dropped |
| ptr_rdata | output | 8 | Pointer byte value when the address hits a pointer byte |

## Verification
`eff_addr`, `rd_zero`, `wr_block` and `ptr_rdata` are combinational from the inputs and the current pointers. They are due in the same cycle the stimulus is applied. The bench drives on the falling edge and compares 2 ns later, before the next rising edge. A pointer update lands on the rising edge that closes the access cycle. It is therefore checked by a later direct byte read, one cycle after the access at the earliest. The carry and borrow steps, the single step under dual strobes, and the stepping suppressed by a pointer-byte write are each observed this way.

// File: rtl/idag_pkg.sv
package idag_pkg;
  localparam int AW   = 12;
  localparam int DW   = 8;
  localparam int NPTR = 3;
  localparam int IW   = 2;

  typedef enum logic [2:0] {
    SL_PLAIN   = 3'd0,
    SL_POSTINC = 3'd1,
    SL_POSTDEC = 3'd2,
    SL_PREINC  = 3'd3,
    SL_INDEXW  = 3'd4,
    SL_HI      = 3'd5,
    SL_LO      = 3'd6,
    SL_NONE    = 3'd7
  } slot_e;

  typedef struct packed {
    logic          hit;
    logic [IW-1:0] idx;
    slot_e         slot;
  } vdec_t;
endpackage

// File: rtl/idag_slot_dec.sv
module idag_slot_dec
  import idag_pkg::*;
#(
  parameter int A_W    = AW,
  parameter int N_PTR  = NPTR,
  parameter int TOP    = 'hFEF,
  parameter int STRIDE = 8
) (
  input  logic [A_W-1:0] addr,
  output vdec_t          res
);
  localparam int SPAN = 6;

  logic [N_PTR-1:0] in_win;
  logic [2:0]       offs [N_PTR];

  for (genvar n = 0; n < N_PTR; n++) begin : g_win
    localparam logic [A_W-1:0] BASE  = A_W'(TOP - STRIDE * n);
    localparam logic [A_W-1:0] FLOOR = A_W'(TOP - STRIDE * n - SPAN);
    logic [A_W-1:0] diff;
    assign diff      = BASE - addr;
    assign in_win[n] = (addr <= BASE) && (addr >= FLOOR);
    assign offs[n]   = diff[2:0];
  end

  always_comb begin
    res.hit  = 1'b0;
    res.idx  = '0;
    res.slot = SL_NONE;
    for (int n = N_PTR - 1; n >= 0; n--) begin
      if (in_win[n]) begin
        res.hit  = 1'b1;
        res.idx  = IW'(n);
        res.slot = slot_e'(offs[n]);
      end
    end
  end
endmodule

// File: rtl/idag_opd_map.sv
module idag_opd_map
  import idag_pkg::*;
#(
  parameter int A_W = AW,
  parameter int D_W = DW,
  parameter int LIM = 'h5F
) (
  input  logic [D_W-1:0]     opd_addr,
  input  logic               opd_bank,
  input  logic [A_W-D_W-1:0] bank_sel,
  input  logic               ext_mode,
  input  logic [A_W-1:0]     base_ptr,
  output logic [A_W-1:0]     lin_addr
);
  localparam int HW = A_W - D_W;

  logic low_half;
  assign low_half = (opd_addr <= D_W'(LIM));

  always_comb begin
    if (opd_bank)
      lin_addr = {bank_sel, opd_addr};
    else if (low_half && ext_mode)
      lin_addr = base_ptr + {{HW{1'b0}}, opd_addr};
    else if (low_half)
      lin_addr = {{HW{1'b0}}, opd_addr};
    else
      lin_addr = {{HW{1'b1}}, opd_addr};
  end
endmodule

// File: rtl/idag_ptr_file.sv
module idag_ptr_file
  import idag_pkg::*;
#(
  parameter int A_W   = AW,
  parameter int D_W   = DW,
  parameter int N_PTR = NPTR
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [N_PTR-1:0]          ld_lo,
  input  logic [N_PTR-1:0]          ld_hi,
  input  logic [D_W-1:0]            ld_data,
  input  logic [N_PTR-1:0]          step_en,
  input  logic                      step_dn,
  output logic [N_PTR-1:0][A_W-1:0] ptr_q
);
  localparam int HW = A_W - D_W;

  for (genvar n = 0; n < N_PTR; n++) begin : g_ptr
    logic [A_W-1:0] cur_q;
    logic [A_W-1:0] nxt;
    logic           upd;

    assign upd = ld_lo[n] | ld_hi[n] | step_en[n];

    always_comb begin
      nxt = cur_q;
      if (ld_lo[n]) nxt[D_W-1:0] = ld_data;
      if (ld_hi[n]) nxt[A_W-1:D_W] = ld_data[HW-1:0];
      if (step_en[n]) nxt = step_dn ? cur_q - 1'b1 : cur_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cur_q <= '0;
      else if (upd) cur_q <= nxt;
    end

    assign ptr_q[n] = cur_q;
  end
endmodule

// File: rtl/ind_addr_gen.sv
module ind_addr_gen
  import idag_pkg::*;
#(
  parameter int A_W     = AW,
  parameter int D_W     = DW,
  parameter int N_PTR   = NPTR,
  parameter int EXT_PTR = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [D_W-1:0]     opd_addr,
  input  logic               opd_bank,
  input  logic [A_W-D_W-1:0] bank_sel,
  input  logic [D_W-1:0]     w_val,
  input  logic               ext_mode,
  input  logic               rd_stb,
  input  logic               wr_stb,
  input  logic [D_W-1:0]     wr_data,
  output logic [A_W-1:0]     eff_addr,
  output logic               rd_zero,
  output logic               wr_block,
  output logic [D_W-1:0]     ptr_rdata
);
  localparam int HW = A_W - D_W;

  // reset: asynchronous assert, synchronous release
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic [N_PTR-1:0][A_W-1:0] ptr_q;
  logic [A_W-1:0]            dir_addr;
  vdec_t                     sd, se;
  logic                      ind, nest, reg_hit, reg_write, any_stb, stepping;
  logic [A_W-1:0]            cur_ptr, w_ext;
  logic [N_PTR-1:0]          ld_lo, ld_hi, step_en;
  logic                      step_dn;

  idag_opd_map #(.A_W(A_W), .D_W(D_W)) u_map (
    .opd_addr (opd_addr),
    .opd_bank (opd_bank),
    .bank_sel (bank_sel),
    .ext_mode (ext_mode),
    .base_ptr (ptr_q[EXT_PTR]),
    .lin_addr (dir_addr)
  );

  idag_slot_dec #(.A_W(A_W), .N_PTR(N_PTR)) u_dec_dir (
    .addr (dir_addr),
    .res  (sd)
  );

  assign ind      = sd.hit && (sd.slot <= SL_INDEXW);
  assign cur_ptr  = ptr_q[sd.idx];
  assign w_ext    = {{HW{w_val[D_W-1]}}, w_val};
  assign stepping = (sd.slot == SL_POSTINC) || (sd.slot == SL_POSTDEC) ||
                    (sd.slot == SL_PREINC);

  always_comb begin
    eff_addr = dir_addr;
    if (ind) begin
      unique case (sd.slot)
        SL_PREINC: eff_addr = cur_ptr + 1'b1;
        SL_INDEXW: eff_addr = cur_ptr + w_ext;
        default:   eff_addr = cur_ptr;
      endcase
    end
  end

  idag_slot_dec #(.A_W(A_W), .N_PTR(N_PTR)) u_dec_eff (
    .addr (eff_addr),
    .res  (se)
  );

  assign nest      = ind && se.hit && (se.slot <= SL_INDEXW);
  assign reg_hit   = se.hit && ((se.slot == SL_HI) || (se.slot == SL_LO));
  assign reg_write = wr_stb && reg_hit;
  assign any_stb   = rd_stb || wr_stb;
  assign rd_zero   = rd_stb && nest;
  assign wr_block  = wr_stb && nest;
  assign step_dn   = (sd.slot == SL_POSTDEC);

  always_comb begin
    for (int n = 0; n < N_PTR; n++) begin
      ld_lo[n]   = reg_write && (se.idx == IW'(n)) && (se.slot == SL_LO);
      ld_hi[n]   = reg_write && (se.idx == IW'(n)) && (se.slot == SL_HI);
      step_en[n] = any_stb && ind && stepping && !reg_write &&
                   (sd.idx == IW'(n));
    end
  end

  always_comb begin
    ptr_rdata = '0;
    if (reg_hit) begin
      if (se.slot == SL_HI) ptr_rdata = {{(D_W-HW){1'b0}}, ptr_q[se.idx][A_W-1:D_W]};
      else                  ptr_rdata = ptr_q[se.idx][D_W-1:0];
    end
  end

  idag_ptr_file #(.A_W(A_W), .D_W(D_W), .N_PTR(N_PTR)) u_ptrs (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .ld_lo   (ld_lo),
    .ld_hi   (ld_hi),
    .ld_data (wr_data),
    .step_en (step_en),
    .step_dn (step_dn),
    .ptr_q   (ptr_q)
  );
endmodule

// File: rtl/idag_chk.sv
module idag_chk
  import idag_pkg::*;
(
  input logic                     clk,
  input logic                     rst_sync_n,
  input logic [DW-1:0]            opd_addr,
  input logic                     opd_bank,
  input logic [AW-DW-1:0]         bank_sel,
  input logic                     ext_mode,
  input logic                     rd_stb,
  input logic                     wr_stb,
  input logic [AW-1:0]            eff_addr,
  input logic                     rd_zero,
  input logic                     wr_block,
  input logic [NPTR-1:0][AW-1:0]  ptr_q
);
  logic [AW-1:0] bank_lin, ext_lin;
  assign bank_lin = {bank_sel, opd_addr};
  assign ext_lin  = ptr_q[2] + {{(AW-DW){1'b0}}, opd_addr};

  assert_zero_needs_read_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rd_zero |-> rd_stb);

  assert_block_needs_write_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wr_block |-> wr_stb);

  assert_idle_hold_R12: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(rd_stb || wr_stb) |=> (ptr_q == $past(ptr_q)));

  assert_bank_direct_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (opd_bank && (bank_lin < 12'hFD9)) |-> (eff_addr == bank_lin));

  assert_low_window_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!opd_bank && !ext_mode && (opd_addr <= 8'h5F)) |-> (eff_addr == {4'h0, opd_addr}));

  assert_ext_offset_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!opd_bank && ext_mode && (opd_addr <= 8'h5F) && (ext_lin < 12'hFD9))
      |-> (eff_addr == ext_lin));

  assert_postinc_step_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (opd_bank && (bank_sel == 4'hF) && (opd_addr == 8'hEE) && rd_stb && !wr_stb)
      |=> (ptr_q[0] == AW'($past(ptr_q[0]) + 1'b1)));

  assert_indexw_keep_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (opd_bank && (bank_sel == 4'hF) && (opd_addr == 8'hEB) && !wr_stb)
      |=> $stable(ptr_q[0]));
endmodule

bind ind_addr_gen idag_chk u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .opd_addr   (opd_addr),
  .opd_bank   (opd_bank),
  .bank_sel   (bank_sel),
  .ext_mode   (ext_mode),
  .rd_stb     (rd_stb),
  .wr_stb     (wr_stb),
  .eff_addr   (eff_addr),
  .rd_zero    (rd_zero),
  .wr_block   (wr_block),
  .ptr_q      (ptr_q)
);

// File: tb/tb_ind_addr_gen.sv
module tb_ind_addr_gen;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] opd_addr, w_val, wr_data, ptr_rdata;
  logic       opd_bank, ext_mode, rd_stb, wr_stb, rd_zero, wr_block;
  logic [3:0] bank_sel;
  logic [11:0] eff_addr;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  ind_addr_gen dut (
    .clk(clk), .rst_n(rst_n), .opd_addr(opd_addr), .opd_bank(opd_bank),
    .bank_sel(bank_sel), .w_val(w_val), .ext_mode(ext_mode),
    .rd_stb(rd_stb), .wr_stb(wr_stb), .wr_data(wr_data),
    .eff_addr(eff_addr), .rd_zero(rd_zero), .wr_block(wr_block),
    .ptr_rdata(ptr_rdata)
  );

  typedef struct {
    logic [11:0] eff;
    logic        rz;
    logic        wb;
    logic [7:0]  rdat;
    string       tag;
  } exp_t;

  exp_t sb[$];

  // monitor: compare 2 ns after the driving edge
  always @(negedge clk) begin
    #2;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      n_chk++;
      if (eff_addr !== e.eff || rd_zero !== e.rz || wr_block !== e.wb ||
          ptr_rdata !== e.rdat) begin
        n_fail++;
        $display("FAIL %s: got eff=%h rz=%b wb=%b rdata=%h, expected eff=%h rz=%b wb=%b rdata=%h",
                 e.tag, eff_addr, rd_zero, wr_block, ptr_rdata, e.eff, e.rz, e.wb, e.rdat);
      end
    end
  end

  task automatic op(input logic a, input logic [3:0] bk, input logic [7:0] opd,
                    input logic [7:0] w, input logic ext, input logic rd,
                    input logic wr, input logic [7:0] dat,
                    input logic [11:0] x_eff, input logic x_rz, input logic x_wb,
                    input logic [7:0] x_rd, input string tag);
    exp_t e;
    @(negedge clk);
    opd_bank = a; bank_sel = bk; opd_addr = opd; w_val = w; ext_mode = ext;
    rd_stb = rd; wr_stb = wr; wr_data = dat;
    e.eff = x_eff; e.rz = x_rz; e.wb = x_wb; e.rdat = x_rd; e.tag = tag;
    sb.push_back(e);
  endtask

  // shorthands on bank F with bank-select addressing
  task automatic rdf(input logic [7:0] opd, input logic ext, input logic [11:0] x_eff,
                     input logic x_rz, input logic [7:0] x_rd, input string tag);
    op(1'b1, 4'hF, opd, 8'h00, ext, 1'b1, 1'b0, 8'h00, x_eff, x_rz, 1'b0, x_rd, tag);
  endtask

  task automatic wrf(input logic [7:0] opd, input logic ext, input logic [7:0] dat,
                     input logic [11:0] x_eff, input logic x_wb, input logic [7:0] x_rd,
                     input string tag);
    op(1'b1, 4'hF, opd, 8'h00, ext, 1'b0, 1'b1, dat, x_eff, 1'b0, x_wb, x_rd, tag);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout, expected completion");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; opd_bank = 1'b0; bank_sel = 4'h0; opd_addr = 8'h00;
    w_val = 8'h00; ext_mode = 1'b0; rd_stb = 1'b0; wr_stb = 1'b0; wr_data = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    rdf(8'hE9, 0, 12'hFE9, 0, 8'h00, "R1 ptr0 lo");
    rdf(8'hEA, 0, 12'hFEA, 0, 8'h00, "R1 ptr0 hi");
    rdf(8'hDA, 0, 12'hFDA, 0, 8'h00, "R1 ptr2 hi");

    // R9 direct pointer byte writes, high nibble of data dropped
    wrf(8'hEA, 0, 8'hAB, 12'hFEA, 0, 8'h00, "R9 write hi");
    rdf(8'hEA, 0, 12'hFEA, 0, 8'h0B, "R9 hi reads nibble");
    wrf(8'hE9, 0, 8'hFF, 12'hFE9, 0, 8'h00, "R9 write lo");

    // R5 post-increment with carry BFF -> C00
    rdf(8'hEE, 0, 12'hBFF, 0, 8'h00, "R5 postinc eff");
    rdf(8'hE9, 0, 12'hFE9, 0, 8'h00, "R5 carry lo");
    rdf(8'hEA, 0, 12'hFEA, 0, 8'h0C, "R5 carry hi");

    // R5 post-decrement with both strobes: single borrow step C00 -> BFF
    op(1, 4'hF, 8'hED, 8'h00, 0, 1, 1, 8'h55, 12'hC00, 0, 0, 8'h00, "R5 postdec dual");
    rdf(8'hE9, 0, 12'hFE9, 0, 8'hFF, "R5 single step lo");
    rdf(8'hEA, 0, 12'hFEA, 0, 8'h0B, "R5 borrow hi");

    // R6 pre-increment BFF -> C00
    rdf(8'hEC, 0, 12'hC00, 0, 8'h00, "R6 preinc eff");
    rdf(8'hEA, 0, 12'hFEA, 0, 8'h0C, "R6 preinc hi");

    // R7 W-indexed, signed W, pointer kept
    op(1, 4'hF, 8'hEB, 8'hF0, 0, 1, 0, 8'h00, 12'hBF0, 0, 0, 8'h00, "R7 negative W");
    op(1, 4'hF, 8'hEB, 8'h05, 0, 1, 0, 8'h00, 12'hC05, 0, 0, 8'h00, "R7 positive W");
    rdf(8'hE9, 0, 12'hFE9, 0, 8'h00, "R7 pointer kept");
    rdf(8'hEF, 0, 12'hC00, 0, 8'h00, "R5 plain eff");

    // R8 pointer 0 aimed at plain slot of pointer 1 (FE7)
    wrf(8'hEA, 0, 8'h0F, 12'hFEA, 0, 8'h0C, "R9 set hi");
    wrf(8'hE9, 0, 8'hE7, 12'hFE9, 0, 8'h00, "R9 set lo");
    rdf(8'hEF, 0, 12'hFE7, 1, 8'h00, "R8 nested read zero");
    wrf(8'hEF, 0, 8'h55, 12'hFE7, 1, 8'h00, "R8 nested write blocked");
    rdf(8'hE1, 0, 12'hFE1, 0, 8'h00, "R8 ptr1 untouched");

    // R10 pointer 2 aimed at its own low byte, write via post-dec and plain
    wrf(8'hDA, 0, 8'h0F, 12'hFDA, 0, 8'h00, "R9 ptr2 hi");
    wrf(8'hD9, 0, 8'hD9, 12'hFD9, 0, 8'h00, "R9 ptr2 lo");
    wrf(8'hDD, 0, 8'h34, 12'hFD9, 0, 8'hD9, "R10 postdec write");
    rdf(8'hD9, 0, 12'hFD9, 0, 8'h34, "R10 no decrement lo");
    rdf(8'hDA, 0, 12'hFDA, 0, 8'h0F, "R10 no decrement hi");
    wrf(8'hD9, 0, 8'hD9, 12'hFD9, 0, 8'h34, "R9 ptr2 lo again");
    wrf(8'hDF, 0, 8'h34, 12'hFD9, 0, 8'hD9, "R10 plain write");
    rdf(8'hD9, 0, 12'hFD9, 0, 8'h34, "R10 same value");

    // R4 extended mode, pointer 2 = F34
    op(0, 4'h0, 8'h10, 8'h00, 1, 1, 0, 8'h00, 12'hF44, 0, 0, 8'h00, "R4 offset 10");
    op(0, 4'h0, 8'h5F, 8'h00, 1, 1, 0, 8'h00, 12'hF93, 0, 0, 8'h00, "R4 offset 5F");
    op(0, 4'h0, 8'h60, 8'h00, 1, 1, 0, 8'h00, 12'hF60, 0, 0, 8'h00, "R4 60 unaffected");
    op(1, 4'h3, 8'h10, 8'h00, 1, 1, 0, 8'h00, 12'h310, 0, 0, 8'h00, "R4 bank unaffected");
    wrf(8'hD9, 1, 8'hFF, 12'hFD9, 0, 8'h34, "R9 ptr2 to FFF");
    op(0, 4'h0, 8'h02, 8'h00, 1, 1, 0, 8'h00, 12'h001, 0, 0, 8'h00, "R4 wrap");

    // R3 / R2 non-extended mapping
    op(0, 4'h0, 8'h5F, 8'h00, 0, 1, 0, 8'h00, 12'h05F, 0, 0, 8'h00, "R3 5F low");
    op(0, 4'h0, 8'h60, 8'h00, 0, 1, 0, 8'h00, 12'hF60, 0, 0, 8'h00, "R3 60 high");
    op(0, 4'h0, 8'h10, 8'h00, 0, 1, 0, 8'h00, 12'h010, 0, 0, 8'h00, "R3 10 low");
    op(1, 4'h5, 8'h80, 8'h00, 0, 1, 0, 8'h00, 12'h580, 0, 0, 8'h00, "R2 bank select");

    // R11 pointer 1 under extended mode, carry 0FF -> 100
    wrf(8'hE1, 1, 8'hFF, 12'hFE1, 0, 8'h00, "R11 ptr1 lo");
    rdf(8'hE6, 1, 12'h0FF, 0, 8'h00, "R11 postinc eff");
    rdf(8'hE2, 1, 12'hFE2, 0, 8'h01, "R11 stepped hi");

    // R12 no strobe, no step
    op(1, 4'hF, 8'hE6, 8'h00, 1, 0, 0, 8'h00, 12'h100, 0, 0, 8'h00, "R12 idle eff");
    op(1, 4'hF, 8'hE6, 8'h00, 1, 0, 0, 8'h00, 12'h100, 0, 0, 8'h00, "R12 idle again");
    rdf(8'hE1, 1, 12'hFE1, 0, 8'h00, "R12 ptr1 unchanged");

    @(negedge clk);
    rd_stb = 1'b0; wr_stb = 1'b0;
    repeat (2) @(negedge clk);
    done = 1'b1;
    finish_run();
  end
endmodule